// File: doc/BRIEF.md
# Zero-Suppressing CDS Pixel Sparsifier

This block sits between a pixel-sample stream and a hit FIFO. Every enabled clock brings one A/D sample together with the 48-bit memory word of the pixel it belongs to. The block always returns a new word to write back: the fresh sample becomes the most recent history entry and the older entries move up by one. Scanning and memory updates never stop.

When a trigger is accepted, the block runs correlated double sampling over exactly one frame. The frame starts at the first pixel sampled in or after the trigger cycle and continues through the address wrap to the pixel just before it. For each pixel it computes the new sample minus the stored previous sample, minus the stored pedestal. Pixels whose result is strictly above the stored threshold are written to the FIFO as hit words. A header comes before them and a trailer follows them. Busy rises when the trigger is accepted and falls only when the host reports that the packet has been drained.

Top module: `sprs_top`

## Requirements
- R1: On every cycle with `smp_valid` high, `mem_we` is high and `mem_wdata` is `{mem_rdata[35:12], smp_data, mem_rdata[11:0]}`. Bits 5:0 (threshold) and 11:6 (pedestal) are kept, 23:12 takes the new sample and the older history moves up. With `smp_valid` low, `mem_we` is low.
- R2: A hit word has tag 2'b10 in bits 31:30, the pixel address in 29:16 and the CDS value in 15:0. The value is `smp_data - mem_rdata[23:12] - mem_rdata[11:6]`. It is written one cycle after its sample.
- R3: A pixel is a hit only when the signed CDS value is strictly greater than `mem_rdata[5:0]`. Equal or negative values are never hits.
- R4: The window begins with the first valid sample in or after the accepting trigger cycle, even if the trigger falls in a sample gap. It ends with the sample whose address equals start minus one, modulo the frame size.
- R5: In the cycle a trigger is accepted, a header word is written: tag 2'b01, bits 29:16 zero, event number in 15:0.
- R6: After the last hit of the window, a trailer word is written: tag 2'b11, overflow in bit 29, count of written hits in 28:16, event number in 15:0.
- R7: `busy` rises the cycle after acceptance. It falls the cycle after `host_done` is seen once the trailer has been written. An earlier `host_done` is ignored.
- R8: A trigger seen while `busy` is high writes no header and does not change the event number.
- R9: A hit meeting `fifo_full` high is not written and sets the trailer overflow bit. Header and trailer are written regardless.
- R10: The event number starts at 0 and increases by one per completed packet. Header and trailer of one packet carry the same number.
- R11: After reset, `busy` and `out_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample enable |
| smp_addr | input | ADDR_W | Pixel address of the sample |
| smp_data | input | SMP_W | A/D sample |
| mem_rdata | input | 48 | Stored word of the sampled pixel |
| mem_we | output | 1 | Write back the pixel word |
| mem_wdata | output | 48 | Updated pixel word |
| trig_in | input | 1 | Trigger pulse |
| host_done | input | 1 | Host has drained the packet |
| busy | output | 1 | Trigger being processed |
| fifo_full | input | 1 | Hit FIFO cannot take hits |
| out_we | output | 1 | FIFO write strobe |
| out_word | output | 32 | Header, hit or trailer word |

## Verification
The FIFO port has two possible users in the same cycle: the header of a newly accepted trigger, and the hit of the sample that arrives in that same cycle. The bench provokes this on purpose by driving the trigger together with a valid sample, including at pixel addresses 0 and 255. It also provokes it with a trigger in a sample gap, where there is no collision. The bench keeps a queue of the words it expects, in order, and every FIFO write is compared with it, so a header and a hit that are swapped, merged or lost show up as a mismatch. A trailer that is due while the last hit is still pending is judged the same way.

// File: rtl/sprs_pkg.sv
package sprs_pkg;
    localparam int OUT_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SCAN,
        ST_TRAIL,
        ST_WAIT
    } sprs_state_e;

    localparam logic [1:0] TAG_HDR = 2'b01;
    localparam logic [1:0] TAG_HIT = 2'b10;
    localparam logic [1:0] TAG_TRL = 2'b11;
endpackage

// File: rtl/sprs_hist_shift.sv
module sprs_hist_shift #(
    parameter int SMP_W = 12,
    parameter int PED_W = 6,
    parameter int THR_W = 6,
    localparam int CFG_W = PED_W + THR_W,
    localparam int KEEP_W = 2 * SMP_W + CFG_W
) (
    input  logic [KEEP_W-1:0]       word_low,
    input  logic [SMP_W-1:0]        sample,
    output logic [KEEP_W+SMP_W-1:0] word_new
);
    // history moves up one field, configuration stays put
    always_comb begin
        word_new = {word_low[KEEP_W-1:CFG_W], sample, word_low[CFG_W-1:0]};
    end
endmodule

// File: rtl/sprs_cds_calc.sv
module sprs_cds_calc #(
    parameter int SMP_W = 12,
    parameter int PED_W = 6,
    parameter int THR_W = 6,
    localparam int DW = SMP_W + 2
) (
    input  logic [SMP_W-1:0] sample,
    input  logic [SMP_W-1:0] prev,
    input  logic [PED_W-1:0] ped,
    input  logic [THR_W-1:0] thr,
    output logic             is_hit,
    output logic [SMP_W-1:0] value
);
    logic signed [DW-1:0] diff;

    always_comb begin
        diff = $signed({2'b00, sample}) - $signed({2'b00, prev})
             - $signed({{(DW-PED_W){1'b0}}, ped});
        is_hit = diff > $signed({{(DW-THR_W){1'b0}}, thr});
        value = diff[SMP_W-1:0];
    end
endmodule

// File: rtl/sprs_top.sv
module sprs_top
    import sprs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SMP_W  = 12,
    parameter int PED_W  = 6,
    parameter int THR_W  = 6,
    parameter int EVT_W  = 16,
    localparam int WORD_W = 3 * SMP_W + PED_W + THR_W,
    localparam int CFG_W  = PED_W + THR_W,
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              trig_in,
    input  logic              host_done,
    output logic              busy,
    input  logic              fifo_full,
    output logic              out_we,
    output logic [OUT_W-1:0]  out_word
);
    typedef struct packed {
        sprs_state_e       st;
        logic              busy;
        logic [ADDR_W-1:0] start;
        logic [EVT_W-1:0]  evt;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic              p_hit;
        logic [ADDR_W-1:0] p_addr;
        logic [SMP_W-1:0]  p_val;
    } sprs_reg_t;

    sprs_reg_t q, d;

    logic             cds_hit;
    logic [SMP_W-1:0] cds_val;
    logic [SMP_W-1:0] oldest_unused;

    assign oldest_unused = mem_rdata[WORD_W-1:WORD_W-SMP_W];

    sprs_hist_shift #(.SMP_W(SMP_W), .PED_W(PED_W), .THR_W(THR_W)) u_hist (
        .word_low (mem_rdata[WORD_W-SMP_W-1:0]),
        .sample   (smp_data),
        .word_new (mem_wdata)
    );

    sprs_cds_calc #(.SMP_W(SMP_W), .PED_W(PED_W), .THR_W(THR_W)) u_cds (
        .sample (smp_data),
        .prev   (mem_rdata[CFG_W+SMP_W-1:CFG_W]),
        .ped    (mem_rdata[CFG_W-1:THR_W]),
        .thr    (mem_rdata[THR_W-1:0]),
        .is_hit (cds_hit),
        .value  (cds_val)
    );

    assign mem_we = smp_valid;
    assign busy   = q.busy;

    logic              accept, first, in_win, last;
    logic [ADDR_W-1:0] start_v;

    always_comb begin
        d        = q;
        d.p_hit  = 1'b0;
        out_we   = 1'b0;
        out_word = '0;

        accept  = trig_in && !q.busy;
        first   = smp_valid && ((q.st == ST_ARM) || (q.st == ST_IDLE && accept));
        in_win  = smp_valid && ((q.st == ST_SCAN) || first);
        start_v = first ? smp_addr : q.start;
        last    = in_win && (smp_addr == start_v - 1'b1);

        // single FIFO write port: header, pending hit, then trailer
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    out_we   = 1'b1;
                    out_word = {TAG_HDR, {(OUT_W-2-EVT_W){1'b0}}, q.evt};
                    d.busy   = 1'b1;
                    d.cnt    = '0;
                    d.ovf    = 1'b0;
                    d.st     = ST_ARM;
                end
            end
            ST_ARM, ST_SCAN, ST_TRAIL: begin
                if (q.p_hit) begin
                    if (fifo_full) begin
                        d.ovf = 1'b1;
                    end else begin
                        out_we   = 1'b1;
                        out_word = {TAG_HIT, {(14-ADDR_W){1'b0}}, q.p_addr,
                                    {(16-SMP_W){1'b0}}, q.p_val};
                        d.cnt    = q.cnt + 1'b1;
                    end
                end else if (q.st == ST_TRAIL) begin
                    out_we   = 1'b1;
                    out_word = {TAG_TRL, q.ovf, {(13-CNT_W){1'b0}}, q.cnt, q.evt};
                    d.evt    = q.evt + 1'b1;
                    d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (host_done) begin
                    d.busy = 1'b0;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (in_win) begin
            d.start  = start_v;
            d.p_hit  = cds_hit;
            d.p_addr = smp_addr;
            d.p_val  = cds_val;
            d.st     = last ? ST_TRAIL : ST_SCAN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sprs_chk.sv
module sprs_chk #(
    parameter int WORD_W = 48,
    parameter int CFG_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              trig_in,
    input logic              host_done,
    input logic              busy,
    input logic              fifo_full,
    input logic              out_we,
    input logic [31:0]       out_word
);
    assert_mem_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mem_we) |-> (mem_wdata[CFG_W-1:0] == mem_rdata[CFG_W-1:0]));

    assert_no_full_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_word[31:30] == 2'b10) |-> !fifo_full);

    assert_hit_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_word[31:30] == 2'b10) |-> (out_word[15:0] != 16'd0));

    assert_hdr_on_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_word[31:30] == 2'b01) |-> (trig_in && !busy));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && busy) |-> !(out_we && out_word[31:30] == 2'b01));

    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig_in) |=> !busy);

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !host_done) |=> busy);
endmodule

bind sprs_top sprs_chk #(.WORD_W(WORD_W), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/sim_sprs_top.sv
module sim_sprs_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_addr = '0;
    logic [11:0] smp_data = '0;
    logic [47:0] mem_rdata = '0;
    logic        mem_we;
    logic [47:0] mem_wdata;
    logic        trig_in = 1'b0;
    logic        host_done = 1'b0;
    logic        busy;
    logic        fifo_full = 1'b0;
    logic        out_we;
    logic [31:0] out_word;

    always #10 clk = ~clk;

    sprs_top u0 (.*);

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    typedef enum {M_IDLE, M_ARM, M_SCAN, M_WAIT} mst_e;
    mst_e        mst = M_IDLE;
    bit          mbusy = 0;
    int          mstart = 0;
    int          mcnt = 0;
    bit          movf = 0;
    logic [15:0] mevt = '0;
    bit          full_b = 0;
    int          paddr = 0;
    logic [47:0] bmem [256];
    bit          force_en [256];
    logic [11:0] force_val [256];
    logic [31:0] expq [$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] gen(input logic [11:0] prev);
        int v;
        v = int'(prev) + int'($urandom_range(56)) - 8;
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return 12'(v);
    endfunction

    task automatic step(input bit t, input bit v, input bit dn);
        logic [11:0] data;
        logic [47:0] old, nw;
        logic [31:0] e;
        int diff;
        @(negedge clk);
        old = bmem[paddr];
        if (force_en[paddr]) begin
            data = force_val[paddr];
            force_en[paddr] = 0;
        end else begin
            data = gen(old[23:12]);
        end
        trig_in = t; host_done = dn; smp_valid = v;
        smp_addr = 8'(paddr); smp_data = data; mem_rdata = old; fifo_full = full_b;
        nw = {old[35:12], data, old[11:0]};
        #8;
        chk(busy == mbusy, "R7 busy", 64'(busy), 64'(mbusy));
        chk(mem_we == v, "R1 mem_we", 64'(mem_we), 64'(v));
        if (v) chk(mem_wdata == nw, "R1 mem_wdata", 64'(mem_wdata), 64'(nw));
        // model: trigger acceptance (header is written this cycle)
        if (t && !mbusy) begin
            expq.push_back({2'b01, 14'd0, mevt});
            mbusy = 1; mst = M_ARM; mcnt = 0; movf = 0;
        end
        if (out_we) begin
            if (expq.size() == 0) begin
                chk(0, "R8 unexpected FIFO write", 64'(out_word), 64'(0));
            end else begin
                e = expq.pop_front();
                chk(out_word == e,
                    e[31:30] == 2'b01 ? "R5 R10 header" :
                    e[31:30] == 2'b10 ? "R2 R3 R4 R9 hit" : "R6 R9 R10 trailer",
                    64'(out_word), 64'(e));
            end
        end
        if (v && (mst == M_ARM || mst == M_SCAN)) begin
            if (mst == M_ARM) begin mstart = paddr; mst = M_SCAN; end
            diff = int'(data) - int'(old[23:12]) - int'(old[11:6]);
            if (diff > int'(old[5:0])) begin
                if (!full_b) begin
                    expq.push_back({2'b10, 6'd0, 8'(paddr), 4'd0, 12'(diff)});
                    mcnt++;
                end else begin
                    movf = 1;
                end
            end
            if (paddr == (mstart + 255) % 256) begin
                expq.push_back({2'b11, movf, 4'd0, 9'(mcnt), mevt});
                mevt = mevt + 1'b1;
                mst = M_WAIT;
            end
        end
        if (dn && mst == M_WAIT) begin mbusy = 0; mst = M_IDLE; end
        if (v) begin bmem[paddr] = nw; paddr = (paddr + 1) % 256; end
    endtask

    task automatic run_event(input bit tv, input bit full);
        int r;
        full_b = full;
        step(1, tv, 0);
        while (mst != M_WAIT) begin
            r = int'($urandom_range(99));
            step(r == 0, r < 75, r == 1);   // R8 trigger while busy, R7 early done
        end
        step(0, 1, 0);
        step(1, 0, 0);                      // R8: trigger after trailer, still busy
        step(0, 1, 0);
        step(0, 0, 1);
        step(0, 1, 0);
        chk(busy == 0, "R7 released", 64'(busy), 64'(0));
        chk(expq.size() == 0, "R6 packet complete", 64'(expq.size()), 64'(0));
        full_b = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            bmem[i] = {12'($urandom), 12'($urandom), 12'($urandom_range(4000)),
                       6'($urandom_range(15)), 6'($urandom_range(20))};
            force_en[i] = 0;
            force_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #8;
        chk(busy == 0, "R11 busy after reset", 64'(busy), 64'(0));
        chk(out_we == 0, "R11 out_we after reset", 64'(out_we), 64'(0));
        // R1: plain streaming, no trigger
        for (int i = 0; i < 300; i++) step(0, $urandom_range(3) != 0, 0);
        // R4: trigger together with a sample, mid frame
        run_event(1, 0);
        // R4: trigger in a gap, window starts with next sample
        run_event(0, 0);
        // R3 directed corners, window starting at address 0
        while (paddr != 0) step(0, 1, 0);
        for (int a = 5; a < 8; a++) bmem[a] = {bmem[a][47:24], 12'd100, 6'd3, 6'd10};
        force_en[5] = 1; force_val[5] = 12'd113;   // equal to threshold: no hit
        force_en[6] = 1; force_val[6] = 12'd114;   // one above: hit value 11
        force_en[7] = 1; force_val[7] = 12'd50;    // negative: no hit
        run_event(1, 0);
        // R4 window starting at the last address
        while (paddr != 255) step(0, 1, 0);
        run_event(1, 0);
        // R9 full FIFO for a whole packet
        run_event(1, 1);
        // random events
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < int'($urandom_range(40)); i++) step(0, $urandom_range(1) != 0, 0);
            run_event($urandom_range(1) != 0, 0);
        end
        chk(mevt == 16'd9, "R10 event count", 64'(mevt), 64'(9));
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule